// File: doc/BRIEF.md
# Out-of-Order Issue Core with Reservation Stations and Result Broadcast

This block is the scheduling heart of a dynamically scheduled execution cluster for one class of arithmetic operations. It accepts instructions in program order through a valid/ready port. Each instruction names a destination register and two source registers. At acceptance the register names are renamed to station tags. Each source is captured either as a value or as the tag of the station that will produce it. The register file is consulted only at that moment.

A station is handed to a pipelined functional unit once both its operands are values. Add, subtract and exclusive-or use a short pipe, and multiply uses a longer one. Finished results wait in their station until they win the single result broadcast bus. That bus wakes every station waiting on the tag. It also updates the register file, but only when the register still names that producer. Later independent instructions may therefore finish and broadcast ahead of earlier long-latency ones.

Top module: `ooo_rs_core`

## Requirements
- R1: `in_ready` is high exactly when at least one of the NRS stations is free. An instruction is accepted on a clock edge with `in_valid` and `in_ready` both high. It takes the lowest-numbered free station, whose tag is its index plus one (tag 0 means "no pending producer"). Issue stalls only when every station is occupied.
- R2: At acceptance, each source whose register has no pending producer is captured as the register's current value. Otherwise it is captured as the producer's tag.
- R3: A station is sent to the functional unit only when both operands are values. At most one station is dispatched per cycle, the oldest-issued ready one. Its result sits in the station LAT_SHORT edges after dispatch for ops 0 to 2, or LAT_LONG edges after dispatch for op 3.
- R4: A broadcast on the result bus is captured by every waiting station whose operand tag equals `cdb_tag`, in the same edge.
- R5: Acceptance overwrites the destination register's status with the new station's tag, so later readers depend on the newest producer of that register.
- R6: Instructions complete and broadcast in data-flow order, not program order. A later independent short operation may broadcast before an earlier multiply.
- R7: A broadcast writes `cdb_data` into register `cdb_dst` and clears its status to "value valid" only if that register's status still equals `cdb_tag`. Otherwise the register is left untouched.
- R8: A source whose producer broadcasts in the same cycle as acceptance is captured as the broadcast value, not as a tag.
- R9: The bus carries at most one result per cycle. When several stations hold results, the oldest-issued wins, and the others keep their results unchanged until they win.
- R10: A station becomes free on the edge that ends its broadcast cycle. While `cdb_valid` is high, `cdb_tag` is in the range 1 to NRS.
- R11: `in_op` encoding: 0 add, 1 subtract (a minus b), 2 exclusive-or, 3 multiply keeping the low W bits. All arithmetic wraps modulo 2^W. After reset, register i holds the value i with no pending producer, and `cdb_valid` is low.
- R12: `cdb_dst` reports the destination register of the broadcasting instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | A station is free |
| in_op | input | 2 | Operation code |
| in_dst | input | RW | Destination register |
| in_src_a | input | RW | First source register |
| in_src_b | input | RW | Second source register |
| cdb_valid | output | 1 | Result broadcast this cycle |
| cdb_tag | output | TAGW | Tag of broadcasting station |
| cdb_dst | output | RW | Destination register of the result |
| cdb_data | output | W | Result value |

## Verification
Independent instructions of each operation check the arithmetic and the short and long latencies. A dependent chain separates operands captured as values from operands captured as tags. A consumer issued exactly in its producer's broadcast cycle exposes a missing same-cycle bypass. Two writes to one register with the older being a slow multiply show whether a stale result overwrites a renamed register. Filling all stations tests the stall. A multiply and an add finishing on the same edge tell oldest-first bus arbitration from youngest-first. A long pseudo-random stream mixes all of these against a behavioural model compared every cycle.

// File: rtl/ooo_rs_pkg.sv
package ooo_rs_pkg;
   typedef enum logic [1:0] {
      OP_ADD = 2'd0,
      OP_SUB = 2'd1,
      OP_XOR = 2'd2,
      OP_MUL = 2'd3
   } alu_op_e;

   typedef enum logic [1:0] {
      RS_FREE,
      RS_WAIT,
      RS_EXEC,
      RS_DONE
   } rs_state_e;
endpackage

// File: rtl/ooo_rs_rename_rf.sv
module ooo_rs_rename_rf #(
   parameter int W    = 16,
   parameter int NREG = 8,
   parameter int RW   = 3,
   parameter int TAGW = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [RW-1:0]   rd_a,
   input  logic [RW-1:0]   rd_b,
   output logic [W-1:0]    val_a,
   output logic [TAGW-1:0] tag_a,
   output logic [W-1:0]    val_b,
   output logic [TAGW-1:0] tag_b,
   input  logic            cdb_valid,
   input  logic [TAGW-1:0] cdb_tag,
   input  logic [RW-1:0]   cdb_dst,
   input  logic [W-1:0]    cdb_data,
   input  logic            iss_en,
   input  logic [RW-1:0]   iss_dst,
   input  logic [TAGW-1:0] iss_tag
);
   logic [W-1:0]    rval [NREG];
   logic [TAGW-1:0] rtag [NREG];

   // read with same-cycle bypass from the broadcast bus
   function automatic logic [TAGW+W-1:0] lookup(input logic [RW-1:0] a);
      logic [TAGW-1:0] t;
      t = rtag[a];
      if (t != '0 && cdb_valid && cdb_tag == t) return {{TAGW{1'b0}}, cdb_data};
      if (t == '0)                              return {{TAGW{1'b0}}, rval[a]};
      return {t, {W{1'b0}}};
   endfunction

   always_comb begin
      {tag_a, val_a} = lookup(rd_a);
      {tag_b, val_b} = lookup(rd_b);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < NREG; r++) begin
            rval[r] <= W'(r);
            rtag[r] <= '0;
         end
      end else begin
         if (cdb_valid && rtag[cdb_dst] == cdb_tag) begin
            rval[cdb_dst] <= cdb_data;
            rtag[cdb_dst] <= '0;
         end
         if (iss_en) rtag[iss_dst] <= iss_tag;
      end
   end

   AST_RF_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
      (cdb_valid && rtag[cdb_dst] == cdb_tag && !(iss_en && iss_dst == cdb_dst))
      |=> (rtag[$past(cdb_dst)] == '0 && rval[$past(cdb_dst)] == $past(cdb_data))); // R7
   AST_RF_STALE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (cdb_valid && rtag[cdb_dst] != cdb_tag)
      |=> (rval[$past(cdb_dst)] == $past(rval[cdb_dst]))); // R7
   AST_RF_RENAME: assert property (@(posedge clk) disable iff (!rst_n)
      iss_en |=> (rtag[$past(iss_dst)] == $past(iss_tag))); // R5
endmodule

// File: rtl/ooo_rs_age_arb.sv
module ooo_rs_age_arb #(
   parameter int NRS = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NRS-1:0] alloc_vec,
   input  logic [NRS-1:0] exec_req,
   input  logic [NRS-1:0] bcast_req,
   output logic [NRS-1:0] exec_gnt,
   output logic [NRS-1:0] bcast_gnt
);
   // older[i][j] set: station i was issued before station j
   logic [NRS-1:0] older [NRS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NRS; i++) older[i] <= '0;
      end else begin
         for (int k = 0; k < NRS; k++) begin
            if (alloc_vec[k]) begin
               for (int j = 0; j < NRS; j++) begin
                  older[k][j] <= 1'b0;
                  if (j != k) older[j][k] <= 1'b1;
               end
            end
         end
      end
   end

   function automatic logic [NRS-1:0] pick_oldest(input logic [NRS-1:0] req);
      logic [NRS-1:0] g;
      for (int i = 0; i < NRS; i++) begin
         logic blk;
         blk = 1'b0;
         for (int j = 0; j < NRS; j++)
            if (j != i && req[j] && older[j][i]) blk = 1'b1;
         g[i] = req[i] && !blk;
      end
      return g;
   endfunction

   always_comb begin
      exec_gnt  = pick_oldest(exec_req);
      bcast_gnt = pick_oldest(bcast_req);
   end

   AST_BUS_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bcast_gnt)); // R9
   AST_BUS_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (bcast_req != '0) |-> (bcast_gnt != '0)); // R9
   AST_DISPATCH_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_req != '0) |-> $onehot(exec_gnt)); // R3
endmodule

// File: rtl/ooo_rs_station.sv
module ooo_rs_station
   import ooo_rs_pkg::*;
#(
   parameter int W    = 16,
   parameter int RW   = 3,
   parameter int TAGW = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            alloc,
   input  alu_op_e         a_op,
   input  logic [RW-1:0]   a_dst,
   input  logic [W-1:0]    a_v1,
   input  logic [TAGW-1:0] a_t1,
   input  logic [W-1:0]    a_v2,
   input  logic [TAGW-1:0] a_t2,
   input  logic            cdb_valid,
   input  logic [TAGW-1:0] cdb_tag,
   input  logic [W-1:0]    cdb_data,
   input  logic            exec_gnt,
   input  logic            res_valid,
   input  logic [W-1:0]    res_data,
   input  logic            bcast_gnt,
   output logic            busy,
   output logic            exec_req,
   output logic            bcast_req,
   output alu_op_e         op,
   output logic [RW-1:0]   dst,
   output logic [W-1:0]    v1,
   output logic [W-1:0]    v2,
   output logic [W-1:0]    result
);
   rs_state_e       st;
   logic [TAGW-1:0] t1, t2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= RS_FREE;
         t1     <= '0;
         t2     <= '0;
         op     <= OP_ADD;
         dst    <= '0;
         v1     <= '0;
         v2     <= '0;
         result <= '0;
      end else if (alloc) begin
         st  <= RS_WAIT;
         op  <= a_op;
         dst <= a_dst;
         v1  <= a_v1;
         t1  <= a_t1;
         v2  <= a_v2;
         t2  <= a_t2;
      end else begin
         unique case (st)
            RS_WAIT: begin
               if (t1 != '0 && cdb_valid && cdb_tag == t1) begin
                  v1 <= cdb_data;
                  t1 <= '0;
               end
               if (t2 != '0 && cdb_valid && cdb_tag == t2) begin
                  v2 <= cdb_data;
                  t2 <= '0;
               end
               if (exec_gnt) st <= RS_EXEC;
            end
            RS_EXEC: if (res_valid) begin
               result <= res_data;
               st     <= RS_DONE;
            end
            RS_DONE: if (bcast_gnt) st <= RS_FREE;
            default: ;
         endcase
      end
   end

   assign busy      = (st != RS_FREE);
   assign exec_req  = (st == RS_WAIT) && t1 == '0 && t2 == '0;
   assign bcast_req = (st == RS_DONE);

   AST_ALLOC_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      alloc |-> (st == RS_FREE)); // R1
   AST_EXEC_HAS_OPERANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (st == RS_EXEC) |-> (t1 == '0 && t2 == '0)); // R3
   AST_RESULT_WHEN_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (st == RS_EXEC)); // R3
   AST_FREE_AFTER_BCAST: assert property (@(posedge clk) disable iff (!rst_n)
      bcast_gnt |=> (st == RS_FREE)); // R10
   AST_LOSER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (st == RS_DONE && !bcast_gnt) |=> (st == RS_DONE && $stable(result))); // R9
endmodule

// File: rtl/ooo_rs_fu_pipe.sv
module ooo_rs_fu_pipe #(
   parameter int W     = 16,
   parameter int TAGW  = 2,
   parameter int DEPTH = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [TAGW-1:0] in_tag,
   input  logic [W-1:0]    in_data,
   output logic            out_valid,
   output logic [TAGW-1:0] out_tag,
   output logic [W-1:0]    out_data
);
   logic [DEPTH-1:0] vld;
   logic [TAGW-1:0]  tg [DEPTH];
   logic [W-1:0]     dt [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld <= '0;
      end else begin
         vld[0] <= in_valid;
         for (int k = 1; k < DEPTH; k++) vld[k] <= vld[k-1];
      end
   end

   always_ff @(posedge clk) begin
      tg[0] <= in_tag;
      dt[0] <= in_data;
      for (int k = 1; k < DEPTH; k++) begin
         tg[k] <= tg[k-1];
         dt[k] <= dt[k-1];
      end
   end

   assign out_valid = vld[DEPTH-1];
   assign out_tag   = tg[DEPTH-1];
   assign out_data  = dt[DEPTH-1];
endmodule

// File: rtl/ooo_rs_core.sv
module ooo_rs_core
   import ooo_rs_pkg::*;
#(
   parameter  int W         = 16,
   parameter  int NREG      = 8,
   parameter  int NRS       = 3,
   parameter  int LAT_SHORT = 1,
   parameter  int LAT_LONG  = 4,
   localparam int RW        = $clog2(NREG),
   localparam int TAGW      = $clog2(NRS + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   output logic            in_ready,
   input  logic [1:0]      in_op,
   input  logic [RW-1:0]   in_dst,
   input  logic [RW-1:0]   in_src_a,
   input  logic [RW-1:0]   in_src_b,
   output logic            cdb_valid,
   output logic [TAGW-1:0] cdb_tag,
   output logic [RW-1:0]   cdb_dst,
   output logic [W-1:0]    cdb_data
);
   localparam int NPIPE = 2;

   if (NRS < 1 || NRS >= (1 << TAGW)) begin : g_bad_nrs
      $error("NRS does not fit the tag width");
   end
   if (LAT_SHORT < 1 || LAT_LONG < LAT_SHORT) begin : g_bad_lat
      $error("latencies must satisfy 1 <= LAT_SHORT <= LAT_LONG");
   end
   if (NREG < 2 || NREG != (1 << RW)) begin : g_bad_nreg
      $error("NREG must be a power of two of at least 2");
   end

   logic [NRS-1:0]  busy, exec_req, bcast_req, exec_gnt, bcast_gnt, alloc_vec, res_v;
   alu_op_e         s_op  [NRS];
   logic [RW-1:0]   s_dst [NRS];
   logic [W-1:0]    s_v1  [NRS], s_v2 [NRS], s_res [NRS], res_d [NRS];
   logic [TAGW-1:0] alloc_tag, rf_ta, rf_tb;
   logic [W-1:0]    rf_va, rf_vb;
   logic            issue_fire;

   assign in_ready   = ~&busy;
   assign issue_fire = in_valid && in_ready;

   always_comb begin
      logic found;
      found     = 1'b0;
      alloc_vec = '0;
      alloc_tag = '0;
      for (int s = 0; s < NRS; s++) begin
         if (!busy[s] && !found) begin
            found        = 1'b1;
            alloc_vec[s] = issue_fire;
            alloc_tag    = TAGW'(s + 1);
         end
      end
   end

   ooo_rs_rename_rf #(.W(W), .NREG(NREG), .RW(RW), .TAGW(TAGW)) u_rf (
      .clk, .rst_n,
      .rd_a(in_src_a), .rd_b(in_src_b),
      .val_a(rf_va), .tag_a(rf_ta), .val_b(rf_vb), .tag_b(rf_tb),
      .cdb_valid, .cdb_tag, .cdb_dst, .cdb_data,
      .iss_en(issue_fire), .iss_dst(in_dst), .iss_tag(alloc_tag)
   );

   ooo_rs_age_arb #(.NRS(NRS)) u_arb (
      .clk, .rst_n, .alloc_vec, .exec_req, .bcast_req, .exec_gnt, .bcast_gnt
   );

   for (genvar s = 0; s < NRS; s++) begin : g_rs
      ooo_rs_station #(.W(W), .RW(RW), .TAGW(TAGW)) u_rs (
         .clk, .rst_n,
         .alloc(alloc_vec[s]), .a_op(alu_op_e'(in_op)), .a_dst(in_dst),
         .a_v1(rf_va), .a_t1(rf_ta), .a_v2(rf_vb), .a_t2(rf_tb),
         .cdb_valid, .cdb_tag, .cdb_data,
         .exec_gnt(exec_gnt[s]), .res_valid(res_v[s]), .res_data(res_d[s]),
         .bcast_gnt(bcast_gnt[s]),
         .busy(busy[s]), .exec_req(exec_req[s]), .bcast_req(bcast_req[s]),
         .op(s_op[s]), .dst(s_dst[s]), .v1(s_v1[s]), .v2(s_v2[s]), .result(s_res[s])
      );
   end

   // broadcast bus: driven by the single granted station
   always_comb begin
      cdb_valid = |bcast_gnt;
      cdb_tag   = '0;
      cdb_dst   = '0;
      cdb_data  = '0;
      for (int s = 0; s < NRS; s++) begin
         if (bcast_gnt[s]) begin
            cdb_tag  = TAGW'(s + 1);
            cdb_dst  = s_dst[s];
            cdb_data = s_res[s];
         end
      end
   end

   function automatic logic [W-1:0] alu(input alu_op_e o, input logic [W-1:0] a, input logic [W-1:0] b);
      unique case (o)
         OP_ADD:  return a + b;
         OP_SUB:  return a - b;
         OP_XOR:  return a ^ b;
         default: return W'(a * b);
      endcase
   endfunction

   logic            go, go_long;
   logic [TAGW-1:0] go_tag;
   logic [W-1:0]    go_res;

   always_comb begin
      go      = |exec_gnt;
      go_long = 1'b0;
      go_tag  = '0;
      go_res  = '0;
      for (int s = 0; s < NRS; s++) begin
         if (exec_gnt[s]) begin
            go_long = (s_op[s] == OP_MUL);
            go_tag  = TAGW'(s + 1);
            go_res  = alu(s_op[s], s_v1[s], s_v2[s]);
         end
      end
   end

   logic            p_vld [NPIPE];
   logic [TAGW-1:0] p_tag [NPIPE];
   logic [W-1:0]    p_dat [NPIPE];

   for (genvar g = 0; g < NPIPE; g++) begin : g_pipe
      localparam int DEPTH = (g == 0) ? LAT_SHORT : LAT_LONG;
      ooo_rs_fu_pipe #(.W(W), .TAGW(TAGW), .DEPTH(DEPTH)) u_pipe (
         .clk, .rst_n,
         .in_valid(go && (go_long == (g == 1))), .in_tag(go_tag), .in_data(go_res),
         .out_valid(p_vld[g]), .out_tag(p_tag[g]), .out_data(p_dat[g])
      );
   end

   always_comb begin
      for (int s = 0; s < NRS; s++) begin
         res_v[s] = 1'b0;
         res_d[s] = '0;
         for (int g = 0; g < NPIPE; g++) begin
            if (p_vld[g] && p_tag[g] == TAGW'(s + 1)) begin
               res_v[s] = 1'b1;
               res_d[s] = p_dat[g];
            end
         end
      end
   end

   AST_DISPATCH_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(exec_gnt)); // R3
   AST_CDB_TAG_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      cdb_valid |-> (cdb_tag != '0 && int'(cdb_tag) <= NRS)); // R10
   AST_PIPES_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
      (p_vld[0] && p_vld[1]) |-> (p_tag[0] != p_tag[1])); // R6
   AST_STALL_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_ready) |=> $stable(busy) || (bcast_gnt != '0) || $past(bcast_gnt != '0)); // R1
endmodule

// File: tb/ooo_rs_core_tb.sv
`timescale 1ns/1ps
module ooo_rs_core_tb;
   localparam int NRS = 3;
   localparam int LS  = 1;
   localparam int LL  = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [1:0]  in_op = '0;
   logic [2:0]  in_dst = '0, in_src_a = '0, in_src_b = '0;
   logic        cdb_valid;
   logic [1:0]  cdb_tag;
   logic [2:0]  cdb_dst;
   logic [15:0] cdb_data;

   always #4 clk = ~clk;

   ooo_rs_core #(.W(16), .NREG(8), .NRS(NRS), .LAT_SHORT(LS), .LAT_LONG(LL)) u_dut (
      .clk, .rst_n, .in_valid, .in_ready, .in_op, .in_dst, .in_src_a, .in_src_b,
      .cdb_valid, .cdb_tag, .cdb_dst, .cdb_data
   );

   int checks = 0, failures = 0, cyc = 0;
   bit finished = 0;
   string cur_req = "R1";

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   // station state: 0 free, 1 waiting, 2 executing, 3 result held
   logic [15:0] m_rv [8];
   int          m_rt [8];
   int          m_st [1:NRS], m_op [1:NRS], m_dst [1:NRS], m_t1 [1:NRS], m_t2 [1:NRS];
   int          m_cnt [1:NRS], m_seq [1:NRS];
   logic [15:0] m_v1 [1:NRS], m_v2 [1:NRS], m_res [1:NRS];
   int          seq_ctr;

   function automatic logic [15:0] calc(int op, logic [15:0] a, logic [15:0] b);
      case (op)
         0: return a + b;
         1: return a - b;
         2: return a ^ b;
         default: return a * b;
      endcase
   endfunction

   function automatic int oldest_in(int want_st, bit need_ops);
      int w = 0;
      for (int s = 1; s <= NRS; s++)
         if (m_st[s] == want_st && (!need_ops || (m_t1[s] == 0 && m_t2[s] == 0)))
            if (w == 0 || m_seq[s] < m_seq[w]) w = s;
      return w;
   endfunction

   function automatic bit m_ready();
      for (int s = 1; s <= NRS; s++) if (m_st[s] == 0) return 1;
      return 0;
   endfunction

   task automatic m_read(input int r, input int cw, output logic [15:0] v, output int t);
      t = m_rt[r];
      v = '0;
      if (t != 0 && cw != 0 && t == cw) begin v = m_res[cw]; t = 0; end
      else if (t == 0) v = m_rv[r];
   endtask

   task automatic m_step();
      int cw, dw, aw, ta, tb;
      logic [15:0] va, vb;
      cw = oldest_in(3, 0);
      dw = oldest_in(1, 1);
      aw = 0;
      if (in_valid) for (int s = NRS; s >= 1; s--) if (m_st[s] == 0) aw = s;
      if (aw != 0) begin
         m_read(int'(in_src_a), cw, va, ta);
         m_read(int'(in_src_b), cw, vb, tb);
      end
      for (int s = 1; s <= NRS; s++)
         if (m_st[s] == 2) begin
            m_cnt[s]--;
            if (m_cnt[s] == 0) begin
               m_st[s]  = 3;
               m_res[s] = calc(m_op[s], m_v1[s], m_v2[s]);
            end
         end
      if (cw != 0) begin
         for (int s = 1; s <= NRS; s++)
            if (m_st[s] == 1) begin
               if (m_t1[s] == cw) begin m_v1[s] = m_res[cw]; m_t1[s] = 0; end
               if (m_t2[s] == cw) begin m_v2[s] = m_res[cw]; m_t2[s] = 0; end
            end
         if (m_rt[m_dst[cw]] == cw) begin
            m_rv[m_dst[cw]] = m_res[cw];
            m_rt[m_dst[cw]] = 0;
         end
         m_st[cw] = 0;
      end
      if (dw != 0) begin
         m_st[dw]  = 2;
         m_cnt[dw] = (m_op[dw] == 3) ? LL : LS;
      end
      if (aw != 0) begin
         m_st[aw] = 1; m_op[aw] = int'(in_op); m_dst[aw] = int'(in_dst);
         m_v1[aw] = va; m_t1[aw] = ta; m_v2[aw] = vb; m_t2[aw] = tb;
         m_seq[aw] = seq_ctr++;
         m_rt[int'(in_dst)] = aw;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         for (int r = 0; r < 8; r++) begin m_rv[r] = 16'(r); m_rt[r] = 0; end
         for (int s = 1; s <= NRS; s++) begin
            m_st[s] = 0; m_t1[s] = 0; m_t2[s] = 0; m_seq[s] = 0; m_cnt[s] = 0;
         end
         seq_ctr = 0;
      end else begin
         m_step();
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         int cw;
         longint act, exp;
         cw = oldest_in(3, 0);
         chk(in_ready == m_ready(), cur_req, "in_ready", longint'(in_ready), longint'(m_ready()));
         act = {cdb_valid, cdb_tag, cdb_dst, (cdb_valid ? cdb_data : 16'h0)};
         exp = (cw == 0) ? 0 : {1'b1, 2'(cw), 3'(m_dst[cw]), m_res[cw]};
         chk(act == exp, cur_req, "cdb {valid,tag,dst,data}", act, exp);
      end
   end

   // ---------------- stimulus ----------------
   task automatic issue(input int op, input int d, input int a, input int b);
      @(negedge clk);
      in_valid = 1'b1;
      in_op = 2'(op); in_dst = 3'(d); in_src_a = 3'(a); in_src_b = 3'(b);
      while (!in_ready) @(negedge clk);
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      in_valid = 1'b0;
      for (int i = 1; i < n; i++) @(negedge clk);
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   always @(posedge clk) begin
      if (cyc > 150000 && !finished) begin
         finished = 1;
         failures++;
         $display("FAIL watchdog expired after %0d cycles", cyc);
         summary();
         $finish;
      end
   end

   initial begin
      logic [15:0] lf;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // reset state (R1, R11)
      #1;
      chk(in_ready == 1'b1, "R1", "ready after reset", longint'(in_ready), 1);
      chk(cdb_valid == 1'b0, "R11", "bus idle after reset", longint'(cdb_valid), 0);

      // each op on reset register values, short and long latency
      cur_req = "R11 R12 R3";
      issue(0, 1, 2, 3);
      issue(1, 4, 2, 5);
      issue(2, 5, 6, 7);
      idle(4);
      issue(3, 6, 7, 3);
      idle(10);

      // dependent chain: value vs tag capture and wake-up
      cur_req = "R2 R4";
      issue(0, 1, 1, 1);
      issue(0, 2, 1, 3);
      issue(1, 3, 2, 1);
      idle(10);

      // same-cycle bypass: consumer accepted exactly in producer's broadcast cycle
      cur_req = "R8";
      issue(3, 7, 2, 2);
      idle(5);
      issue(0, 0, 7, 7);
      idle(10);
      issue(0, 3, 4, 4);
      issue(2, 5, 3, 1);
      idle(8);

      // renaming: slow older write and fast newer write to the same register
      cur_req = "R5 R7";
      issue(3, 3, 4, 5);
      issue(0, 6, 3, 0);
      issue(0, 3, 1, 1);
      idle(12);
      issue(0, 7, 3, 0);
      idle(8);

      // fill every station: stall, then reuse of freed stations
      cur_req = "R1 R10";
      issue(3, 1, 2, 3);
      issue(0, 2, 1, 1);
      issue(0, 3, 2, 1);
      issue(1, 4, 3, 2);
      issue(0, 5, 4, 4);
      idle(14);

      // out-of-order completion and bus contention: mul and add finish together
      cur_req = "R6 R9";
      issue(3, 1, 5, 6);
      idle(2);
      issue(0, 2, 3, 4);
      idle(10);
      issue(3, 4, 1, 1);
      issue(3, 5, 2, 2);
      issue(0, 6, 0, 3);
      idle(14);

      // mixed pseudo-random stream
      cur_req = "R1 R2 R4 R5 R6 R7 R8 R9 R10";
      lf = 16'hACE1;
      for (int n = 0; n < 80; n++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         issue(int'(lf[1:0]), int'(lf[4:2]), int'(lf[7:5]), int'(lf[10:8]));
         if (lf[15] && lf[14]) idle(int'(lf[13:12]) + 1);
      end
      idle(30);

      finished = 1;
      summary();
      $finish;
   end
endmodule